// File: doc/BRIEF.md
# Chained Descriptor Memory-to-Memory DMA

This block copies data between two memory-mapped regions, for instance a host-side window and local SDRAM. Software hands it transfer descriptors. Each descriptor gives a source address, a destination address and a length in bytes, and goes into a small on-chip queue. A dispatcher takes one descriptor at a time and loads a read engine and a write engine with it. When the final write of one descriptor is accepted, the dispatcher moves on to the next queued descriptor in that same cycle, so transfers run back to back with no software turnaround.

The read engine sends burst requests to the source side and may keep several of them outstanding, which hides a long return latency. Returned beats go into a valid/ready stream buffer. The write engine drains that buffer with single-beat writes toward the destination. The two engines are linked only by this stream, so a clock-crossing FIFO could be placed between them. A new burst is admitted only when the buffer has room for every beat already requested plus the new burst, so returned data never overruns it.

Top module: `chain_dma`

## Requirements
- R1: A descriptor is taken when `descValid` and `descReady` are both high at a clock edge. The low three bits of `descSrc`, `descDst` and `descLen` are ignored, which gives 8-byte aligned addresses and a length of `descLen[31:3]` 64-bit beats.
- R2: The queue holds up to 8 descriptors. `queueCount` gives the number waiting (not yet dispatched), and `descReady` is low exactly when 8 are waiting.
- R3: A descriptor whose length is under 8 bytes (zero beats) completes the handshake but is discarded: it is never queued and never executed.
- R4: Descriptors run in the order they were accepted. The next one is dispatched in the same cycle as the final write handshake of the current one. When the engine is idle, a waiting descriptor is dispatched in the cycle after it is accepted.
- R5: Read bursts for a descriptor go to source + 128·k. `rdLen` counts beats and is min(16, beats still unrequested). A request holds its address and length stable until `rdReqReady` is seen.
- R6: A burst is requested only when (beats requested but not yet returned) + (beats buffered but not yet written) + `rdLen` ≤ 32.
- R7: The read engine does not wait for data before issuing its next burst, so more than one burst can be outstanding.
- R8: Writes are single beats at destination + 8·i. The data is the i-th beat read from the source. `wrValid` is high exactly when a returned beat is waiting to be written.
- R9: `done` is a one-cycle pulse, high in the cycle of each descriptor's final write handshake.
- R10: `busy` is high while a descriptor is queued or being executed.
- R11: A synchronous `rst` empties the queue and aborts any transfer. After it, `busy`, `rdReqValid` and `wrValid` are low and `queueCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, flushes queue and aborts transfer |
| descValid | input | 1 | Descriptor offered |
| descReady | output | 1 | Queue has room |
| descSrc | input | 32 | Source byte address |
| descDst | input | 32 | Destination byte address |
| descLen | input | 32 | Transfer length in bytes |
| queueCount | output | 4 | Descriptors waiting |
| busy | output | 1 | Work queued or in flight |
| done | output | 1 | Descriptor finished pulse |
| rdReqValid | output | 1 | Read burst request |
| rdReqReady | input | 1 | Read request accepted |
| rdAddr | output | 32 | Read burst byte address |
| rdLen | output | 5 | Read burst length in beats |
| rdDataValid | input | 1 | Returned read beat |
| rdData | input | 64 | Returned read data |
| wrValid | output | 1 | Write beat valid |
| wrReady | input | 1 | Write beat accepted |
| wrAddr | output | 32 | Write byte address |
| wrData | output | 64 | Write data |

## Verification
The bench runs a behavioural model next to the design and compares every request, every write, the done pulse and the status outputs on every clock. The stimulus has six parts:
- A short three-beat copy, which checks the basic path.
- A descriptor with unaligned addresses and an odd length, which shows the low address and length bits are dropped.
- A zero-beat descriptor, which shows it is discarded rather than queued.
- An 800-byte copy against a throttled write port, which separates correct final-burst shortening, buffer-space admission and overlapping outstanding bursts from a read engine that waits for each burst.
- Nine descriptors pushed while writes are stalled, then released. This fills the queue to check the full back-pressure, and shows the exact zero-gap chaining and the in-order execution.
- A reset in the middle of a long copy, followed by a fresh short copy, which shows the abort and a clean restart.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 64;
  localparam int BYTE_SHIFT = $clog2(DATA_W / 8);
  localparam int WORD_W     = ADDR_W - BYTE_SHIFT;

  // Strobes and operands handed from control to datapath
  typedef struct packed {
    logic              start;
    logic [WORD_W-1:0] srcWord;
    logic [WORD_W-1:0] dstWord;
    logic [WORD_W-1:0] beats;
  } dispatchCmd_t;
endpackage

// File: rtl/chain_dma_stream_fifo.sv
module chain_dma_stream_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [WIDTH-1:0]             din,
  input  logic                         pop,
  output logic [WIDTH-1:0]             dout,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  assign dout  = mem[rdPtr];
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // R6: credit admission must keep every return inside the buffer
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push && !pop |-> count < CNT_W'(DEPTH));
endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
  import chain_dma_pkg::*;
#(
  parameter int QUEUE_DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             descValid,
  output logic                             descReady,
  input  logic [ADDR_W-1:0]                descSrc,
  input  logic [ADDR_W-1:0]                descDst,
  input  logic [ADDR_W-1:0]                descLen,
  input  logic                             lastWrite,
  output dispatchCmd_t                     cmd,
  output logic [$clog2(QUEUE_DEPTH+1)-1:0] queueCount,
  output logic                             busy,
  output logic                             done
);
  localparam int PTR_W = $clog2(QUEUE_DEPTH);
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

  logic [WORD_W-1:0] srcMem  [QUEUE_DEPTH];
  logic [WORD_W-1:0] dstMem  [QUEUE_DEPTH];
  logic [WORD_W-1:0] beatMem [QUEUE_DEPTH];
  logic [PTR_W-1:0]  headPtr, tailPtr;
  logic [CNT_W-1:0]  count;
  logic              active;
  logic              push, start;
  logic [WORD_W-1:0] newBeats;
  logic              unusedLowBits;

  assign unusedLowBits = ^{descSrc[BYTE_SHIFT-1:0], descDst[BYTE_SHIFT-1:0],
                           descLen[BYTE_SHIFT-1:0]};
  assign newBeats  = descLen[ADDR_W-1:BYTE_SHIFT];
  assign descReady = (count != CNT_W'(QUEUE_DEPTH));
  assign push      = descValid && descReady && (newBeats != '0);
  assign start     = (!active || lastWrite) && (count != '0);

  assign cmd.start   = start;
  assign cmd.srcWord = srcMem[headPtr];
  assign cmd.dstWord = dstMem[headPtr];
  assign cmd.beats   = beatMem[headPtr];

  assign queueCount = count;
  assign busy       = active || (count != '0);
  assign done       = lastWrite;

  always_ff @(posedge clk) begin
    if (push) begin
      srcMem[tailPtr]  <= descSrc[ADDR_W-1:BYTE_SHIFT];
      dstMem[tailPtr]  <= descDst[ADDR_W-1:BYTE_SHIFT];
      beatMem[tailPtr] <= newBeats;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
      active  <= 1'b0;
    end else begin
      if (push)  tailPtr <= tailPtr + 1'b1;
      if (start) headPtr <= headPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(start);
      if (start)          active <= 1'b1;
      else if (lastWrite) active <= 1'b0;
    end
  end

  // R9: a completion can only come from a dispatched descriptor
  a_r9_done_in_flight: assert property (@(posedge clk) disable iff (rst)
    lastWrite |-> active);
  // R2: occupancy never exceeds the queue size
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(QUEUE_DEPTH));
  // R4: a completion with work waiting keeps the engine running
  a_r4_chain_no_gap: assert property (@(posedge clk) disable iff (rst)
    lastWrite && count != '0 |=> active);
  // R11: reset leaves nothing queued or running
  a_r11_reset_flush: assert property (@(posedge clk)
    rst |=> (count == '0) && !active);
endmodule

// File: rtl/chain_dma_datapath.sv
module chain_dma_datapath
  import chain_dma_pkg::*;
#(
  parameter int STREAM_DEPTH = 32,
  parameter int MAX_BURST    = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  dispatchCmd_t                   cmd,
  output logic                           rdReqValid,
  input  logic                           rdReqReady,
  output logic [ADDR_W-1:0]              rdAddr,
  output logic [$clog2(MAX_BURST+1)-1:0] rdLen,
  input  logic                           rdDataValid,
  input  logic [DATA_W-1:0]              rdData,
  output logic                           wrValid,
  input  logic                           wrReady,
  output logic [ADDR_W-1:0]              wrAddr,
  output logic [DATA_W-1:0]              wrData,
  output logic                           lastWrite
);
  localparam int CNT_W = $clog2(STREAM_DEPTH + 1);
  localparam int LEN_W = $clog2(MAX_BURST + 1);
  localparam int SUM_W = CNT_W + 2;

  logic [WORD_W-1:0] rdWord, rdRemain, wrWord, wrRemain;
  logic [CNT_W-1:0]  inflight, fifoCount;
  logic [LEN_W-1:0]  burstBeats;
  logic [SUM_W-1:0]  committed;
  logic              reqFire, wrFire, fifoEmpty;

  assign burstBeats = (rdRemain > WORD_W'(MAX_BURST)) ? LEN_W'(MAX_BURST)
                                                      : rdRemain[LEN_W-1:0];
  assign committed  = SUM_W'(fifoCount) + SUM_W'(inflight) + SUM_W'(burstBeats);
  assign rdReqValid = (rdRemain != '0) && (committed <= SUM_W'(STREAM_DEPTH));
  assign reqFire    = rdReqValid && rdReqReady;
  assign rdAddr     = {rdWord, {BYTE_SHIFT{1'b0}}};
  assign rdLen      = burstBeats;

  assign wrValid    = !fifoEmpty && (wrRemain != '0);
  assign wrFire     = wrValid && wrReady;
  assign wrAddr     = {wrWord, {BYTE_SHIFT{1'b0}}};
  assign lastWrite  = wrFire && (wrRemain == WORD_W'(1));

  chain_dma_stream_fifo #(.WIDTH(DATA_W), .DEPTH(STREAM_DEPTH)) i_stream (
    .clk(clk), .rst(rst), .push(rdDataValid), .din(rdData), .pop(wrFire),
    .dout(wrData), .empty(fifoEmpty), .count(fifoCount));

  always_ff @(posedge clk) begin
    if (rst) begin
      rdWord   <= '0;
      rdRemain <= '0;
      wrWord   <= '0;
      wrRemain <= '0;
      inflight <= '0;
    end else begin
      if (cmd.start) begin
        rdWord   <= cmd.srcWord;
        rdRemain <= cmd.beats;
        wrWord   <= cmd.dstWord;
        wrRemain <= cmd.beats;
      end else begin
        if (reqFire) begin
          rdWord   <= rdWord + WORD_W'(burstBeats);
          rdRemain <= rdRemain - WORD_W'(burstBeats);
        end
        if (wrFire) begin
          wrWord   <= wrWord + 1'b1;
          wrRemain <= wrRemain - 1'b1;
        end
      end
      inflight <= inflight + (reqFire ? CNT_W'(burstBeats) : '0) - CNT_W'(rdDataValid);
    end
  end

  // R5: a pending request keeps its address and length
  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    rdReqValid && !rdReqReady |=> rdReqValid && $stable(rdAddr) && $stable(rdLen));
  // R5: burst length is within one to the burst limit
  a_r5_len_range: assert property (@(posedge clk) disable iff (rst)
    rdReqValid |-> (rdLen != '0) && (rdLen <= LEN_W'(MAX_BURST)));
  // R4: a new descriptor starts on a drained stream
  a_r4_start_drained: assert property (@(posedge clk) disable iff (rst)
    cmd.start |-> (inflight == '0) && (rdRemain == '0));
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int QUEUE_DEPTH  = 8,
  parameter int STREAM_DEPTH = 32,
  parameter int MAX_BURST    = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             descValid,
  output logic                             descReady,
  input  logic [31:0]                      descSrc,
  input  logic [31:0]                      descDst,
  input  logic [31:0]                      descLen,
  output logic [$clog2(QUEUE_DEPTH+1)-1:0] queueCount,
  output logic                             busy,
  output logic                             done,
  output logic                             rdReqValid,
  input  logic                             rdReqReady,
  output logic [31:0]                      rdAddr,
  output logic [$clog2(MAX_BURST+1)-1:0]   rdLen,
  input  logic                             rdDataValid,
  input  logic [63:0]                      rdData,
  output logic                             wrValid,
  input  logic                             wrReady,
  output logic [31:0]                      wrAddr,
  output logic [63:0]                      wrData
);
  dispatchCmd_t cmd;
  logic         lastWrite;

  chain_dma_ctrl #(.QUEUE_DEPTH(QUEUE_DEPTH)) i_ctrl (
    .clk(clk), .rst(rst), .descValid(descValid), .descReady(descReady),
    .descSrc(descSrc), .descDst(descDst), .descLen(descLen),
    .lastWrite(lastWrite), .cmd(cmd), .queueCount(queueCount),
    .busy(busy), .done(done));

  chain_dma_datapath #(.STREAM_DEPTH(STREAM_DEPTH), .MAX_BURST(MAX_BURST)) i_datapath (
    .clk(clk), .rst(rst), .cmd(cmd),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdAddr(rdAddr), .rdLen(rdLen),
    .rdDataValid(rdDataValid), .rdData(rdData),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .lastWrite(lastWrite));
endmodule

// File: tb/test_chain_dma.sv
module test_chain_dma;
  localparam int LAT = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1, descValid = 1'b0, descReady;
  logic [31:0] descSrc = '0, descDst = '0, descLen = '0;
  logic [3:0]  queueCount;
  logic        busy, done, rdReqValid, rdReqReady = 1'b0;
  logic [31:0] rdAddr;
  logic [4:0]  rdLen;
  logic        rdDataValid = 1'b0;
  logic [63:0] rdData = '0;
  logic        wrValid, wrReady = 1'b0;
  logic [31:0] wrAddr;
  logic [63:0] wrData;

  chain_dma i_chain_dma (.*);

  int checks = 0, failures = 0, cyc = 0;
  // stimulus drive values, applied at the falling edge
  bit pendRst = 1'b1, pendValid = 1'b0;
  logic [31:0] pendSrc, pendDst, pendLen;
  int wrMode = 0;
  bit lastAccepted, retDrv;
  // behavioural model
  int unsigned mq[$];
  int unsigned mLeft = 0;
  bit mActive = 1'b0;
  logic [31:0] expRdAddr[$], expWrAddr[$], expWrSrc[$], retAddr[$];
  int expRdLen[$], retDue[$];
  bit retLast[$];
  int outBeats = 0, heldBeats = 0, reqsOut = 0, maxReqs = 0, doneCount = 0;

  function automatic logic [63:0] hostWord(input logic [31:0] a);
    return {a ^ 32'hA5A5_0F0F, ~a + 32'd7};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic modelClear();
    mq.delete(); expRdAddr.delete(); expRdLen.delete(); expWrAddr.delete();
    expWrSrc.delete(); retAddr.delete(); retDue.delete(); retLast.delete();
    mActive = 0; mLeft = 0; outBeats = 0; heldBeats = 0; reqsOut = 0;
  endtask

  task automatic evaluate();
    int sumPre;
    bit lastW, start;
    sumPre = outBeats + heldBeats;
    chk(queueCount == 4'(mq.size()), "R2 queueCount", queueCount, mq.size());
    chk(descReady == (mq.size() < 8), "R2 descReady", descReady, mq.size() < 8);
    chk(busy == (mActive || mq.size() != 0), "R10 busy", busy, mActive || mq.size() != 0);
    chk(wrValid == (heldBeats > 0), "R8 wrValid", wrValid, heldBeats > 0);
    // read requests
    if (rdReqValid) begin
      if (expRdAddr.size() == 0) chk(0, "R5 unexpected request", rdAddr, 0);
      else begin
        chk(rdAddr == expRdAddr[0], "R1 R5 rdAddr", rdAddr, expRdAddr[0]);
        chk(rdLen == 5'(expRdLen[0]), "R5 rdLen", rdLen, expRdLen[0]);
        chk(sumPre + int'(rdLen) <= 32, "R6 buffer space", sumPre + rdLen, 32);
        if (rdReqReady) begin
          for (int k = 0; k < int'(rdLen); k++) begin
            retAddr.push_back(rdAddr + 32'(8 * k));
            retDue.push_back(cyc + LAT + k);
            retLast.push_back(k == int'(rdLen) - 1);
          end
          outBeats += int'(rdLen);
          void'(expRdAddr.pop_front()); void'(expRdLen.pop_front());
          reqsOut++;
          if (reqsOut > maxReqs) maxReqs = reqsOut;
        end
      end
    end
    // writes
    lastW = 0;
    if (wrValid && wrReady) begin
      if (expWrAddr.size() == 0) chk(0, "R8 unexpected write", wrAddr, 0);
      else begin
        chk(wrAddr == expWrAddr[0], "R1 R8 wrAddr", wrAddr, expWrAddr[0]);
        chk(wrData == hostWord(expWrSrc[0]), "R8 wrData", wrData, hostWord(expWrSrc[0]));
        void'(expWrAddr.pop_front()); void'(expWrSrc.pop_front());
      end
      heldBeats--;
      lastW = (mLeft == 1);
      mLeft--;
    end
    chk(done == lastW, "R9 done", done, lastW);
    if (lastW) doneCount++;
    // returned beat
    if (retDrv) begin
      void'(retAddr.pop_front()); void'(retDue.pop_front());
      if (retLast.pop_front()) reqsOut--;
      outBeats--; heldBeats++;
    end
    // descriptor queue and dispatch
    lastAccepted = descValid && descReady;
    start = (!mActive || lastW) && mq.size() != 0;
    if (start) begin mLeft = mq.pop_front(); mActive = 1; end
    else if (lastW) mActive = 0;
    if (lastAccepted && descLen[31:3] != 0) begin
      int unsigned beats;
      logic [31:0] s, d;
      beats = descLen[31:3];
      s = descSrc & ~32'h7;
      d = descDst & ~32'h7;
      mq.push_back(beats);
      for (int unsigned i = 0; i < beats; i += 16) begin
        expRdAddr.push_back(s + 8 * i);
        expRdLen.push_back((beats - i > 16) ? 16 : int'(beats - i));
      end
      for (int unsigned i = 0; i < beats; i++) begin
        expWrAddr.push_back(d + 8 * i);
        expWrSrc.push_back(s + 8 * i);
      end
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      summary();
      $finish;
    end
    rst       = pendRst;
    descValid = pendValid;
    descSrc   = pendSrc;
    descDst   = pendDst;
    descLen   = pendLen;
    wrReady   = (wrMode == 0) ? 1'b1 : (wrMode == 1) ? (cyc % 3 != 0) : 1'b0;
    rdReqReady = (cyc % 4 != 1);
    retDrv = (!pendRst && retDue.size() != 0 && retDue[0] <= cyc);
    rdDataValid = retDrv;
    rdData = retDrv ? hostWord(retAddr[0]) : '0;
    #2;
    if (pendRst) begin modelClear(); lastAccepted = 0; end
    else evaluate();
  endtask

  task automatic tryPush(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l, output bit ok);
    pendValid = 1; pendSrc = s; pendDst = d; pendLen = l;
    tick();
    ok = lastAccepted;
    pendValid = 0;
  endtask

  task automatic pushDesc(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l);
    bit ok;
    ok = 0;
    while (!ok) tryPush(s, d, l, ok);
  endtask

  task automatic waitIdle();
    int n;
    n = 0;
    while ((mActive || mq.size() != 0 || expWrAddr.size() != 0) && n < 20000) begin
      tick(); n++;
    end
    chk(n < 20000, "R4 transfer finishes", n, 20000);
  endtask

  initial begin
    bit ok;
    int d0;
    pendSrc = '0; pendDst = '0; pendLen = '0;
    repeat (3) tick();
    pendRst = 0;
    tick();
    chk(queueCount == 0 && !busy && descReady && !rdReqValid && !wrValid && !done,
        "R11 reset state", {queueCount, busy, rdReqValid, wrValid}, 0);

    wrMode = 0;
    pushDesc(32'h1000, 32'h8000, 32'd24);
    waitIdle();
    chk(doneCount == 1, "R9 single done", doneCount, 1);

    pushDesc(32'h2003, 32'h9005, 32'h45);   // R1: low bits dropped, 8 beats
    waitIdle();
    chk(doneCount == 2, "R1 unaligned descriptor done", doneCount, 2);

    tryPush(32'h3000, 32'h4000, 32'd4, ok);
    chk(ok, "R3 handshake completes", ok, 1);
    tick();
    chk(queueCount == 0 && !busy, "R3 zero-beat discarded", {queueCount, busy}, 0);

    wrMode = 1;
    pushDesc(32'h10000, 32'h20000, 32'd800);
    waitIdle();
    chk(maxReqs >= 2, "R7 overlapping bursts", maxReqs, 2);
    chk(doneCount == 3, "R9 long done", doneCount, 3);

    wrMode = 2;
    for (int i = 0; i < 9; i++)
      pushDesc(32'h30000 + 32'(i * 256), 32'h40000 + 32'(i * 256), 32'(8 * (i + 3)));
    tick();
    chk(queueCount == 8, "R2 queue full count", queueCount, 8);
    chk(!descReady, "R2 full backpressure", descReady, 0);
    tryPush(32'h50000, 32'h60000, 32'd64, ok);
    chk(!ok, "R2 full rejects", ok, 0);
    wrMode = 0;
    waitIdle();
    chk(doneCount == 12, "R4 chained descriptors all done", doneCount, 12);

    wrMode = 1;
    pushDesc(32'h50000, 32'h60000, 32'd2048);
    repeat (60) tick();
    chk(busy, "R10 busy mid transfer", busy, 1);
    pendRst = 1; tick(); pendRst = 0;
    tick();
    chk(queueCount == 0 && !busy && !wrValid && !rdReqValid, "R11 abort",
        {queueCount, busy, wrValid, rdReqValid}, 0);
    d0 = doneCount;
    pushDesc(32'h7000, 32'h7800, 32'd40);
    waitIdle();
    chk(doneCount == d0 + 1, "R11 restart after abort", doneCount, d0 + 1);

    summary();
    $finish;
  end
endmodule